// File: doc/BRIEF.md
# Dual-Frequency DDS Phase Generator

This block is the phase-generation front end of a direct digital synthesizer. It holds two 32-bit tuning words and four 12-bit phase offsets. A free-running 32-bit accumulator adds one of the two tuning words on every clock. The upper twelve bits of the accumulator, plus one of the four offsets, form a registered 12-bit phase word. A sine lookup further down the chain can consume that word directly.

The registers are loaded through a 16-bit parallel write port with a 3-bit address. Each tuning word is written as two 16-bit halves. A one-bit frequency-select pin and a two-bit phase-select pin choose the active tuning word and the active offset on every clock. This allows frequency-shift and phase-shift keying without any register traffic. Switching either selection never clears the accumulator, so the phase stays continuous.

The output frequency equals the tuning word divided by 2^32, times the clock rate. For example, a 50 MHz clock with word 0x547AE148 gives 16.5 MHz.

Top module: `dds_phase_gen`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises with no write, acc_o and phase_o are zero and all six registers are zero.
- R2: On every rising clock edge, acc_o becomes acc_o plus the selected tuning word, modulo 2^32.
- R3: fsel_i = 0 selects tuning word 0 as the increment; fsel_i = 1 selects tuning word 1.
- R4: Address 000 writes bits 15..0 of tuning word 0, 001 writes its bits 31..16, 010 writes bits 15..0 of tuning word 1, and 011 writes its bits 31..16. The other half is left unchanged.
- R5: Addresses 100, 101, 110 and 111 write offsets 0, 1, 2 and 3 from wr_data_i[11:0]. wr_data_i[15:12] has no effect.
- R6: psel_i selects offset psel_i: 00 selects offset 0, 01 offset 1, 10 offset 2 and 11 offset 3.
- R7: After each edge, phase_o equals acc_o[31:20] plus the offset chosen by psel_i at that edge, modulo 2^12.
- R8: A write with wr_en_i high takes effect at that clock edge. The accumulation at the same edge still uses the old tuning word, and the new value is first used at the following edge.
- R9: Changing fsel_i or psel_i does not reset or reload the accumulator.
- R10: With wr_en_i low, wr_addr_i and wr_data_i change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle register write enable |
| wr_addr_i | input | 3 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| fsel_i | input | 1 | Tuning word select |
| psel_i | input | 2 | Phase offset select |
| acc_o | output | 32 | Phase accumulator value |
| phase_o | output | 12 | Accumulator top bits plus selected offset |

## Verification
A corrupted tuning-word half shows up at the very next edge as a wrong acc_o increment. From then on the error is permanent, because the accumulator integrates it. A wrong offset register or a misdecoded select shows only in phase_o. It appears in the cycle after the edge that selects that offset, while acc_o stays correct. The bench therefore compares both outputs against a reference model after every single clock, so any divergence is caught one cycle after its cause.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FREQ_W  = 32;
  localparam int unsigned PHASE_W = 12;
  localparam int unsigned N_TW    = 2;
  localparam int unsigned N_OFF   = 4;
  localparam int unsigned ADDR_W  = 3;

  // top address bit splits the map into tuning and offset halves
  typedef enum logic {
    SPACE_TUNE  = 1'b0,
    SPACE_PHASE = 1'b1
  } addr_space_e;
endpackage

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
  import dds_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned FW   = FREQ_W,
  parameter int unsigned PW   = PHASE_W,
  parameter int unsigned NT   = N_TW,
  parameter int unsigned NO   = N_OFF,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [NT-1:0][FW-1:0] tw_o,
  output logic [NO-1:0][PW-1:0] off_o
);
  localparam int unsigned HALVES = FW / DW;
  localparam int unsigned HB     = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int unsigned TB     = (NT > 1) ? $clog2(NT) : 1;
  localparam int unsigned OB     = (NO > 1) ? $clog2(NO) : 1;

  addr_space_e     space;
  logic [HB-1:0]   half_sel;
  logic [TB-1:0]   tw_sel;
  logic [OB-1:0]   off_sel;

  always_comb begin
    space    = addr_space_e'(wr_addr_i[AW-1]);
    half_sel = wr_addr_i[HB-1:0];
    tw_sel   = wr_addr_i[HB +: TB];
    off_sel  = wr_addr_i[OB-1:0];
  end

  for (genvar g = 0; g < NT; g++) begin : g_tw
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en_i && (space == SPACE_TUNE) &&
                   (tw_sel == TB'(g)) && (half_sel == HB'(h));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_data_i;
      end
      assign tw_o[g][h*DW +: DW] = q;
    end
  end

  for (genvar k = 0; k < NO; k++) begin : g_off
    logic [PW-1:0] q;
    logic          hit;
    assign hit = wr_en_i && (space == SPACE_PHASE) && (off_sel == OB'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wr_data_i[PW-1:0]; // upper data bits dropped
    end
    assign off_o[k] = q;
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned NT = N_TW,
  localparam int unsigned SW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NT-1:0][FW-1:0] tw_i,
  input  logic [SW-1:0]         fsel_i,
  output logic [FW-1:0]         acc_o,
  output logic [FW-1:0]         acc_nxt_o
);
  logic [FW-1:0] acc_q;

  assign acc_nxt_o = acc_q + tw_i[fsel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_nxt_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_offset.sv
module dds_phase_offset
  import dds_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned NO = N_OFF,
  localparam int unsigned SW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [FW-1:0]         acc_nxt_i,
  input  logic [NO-1:0][PW-1:0] off_i,
  input  logic [SW-1:0]         psel_i,
  output logic [PW-1:0]         phase_o
);
  logic [PW-1:0] phase_q;

  // registered alongside the accumulator so both outputs align
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= acc_nxt_i[FW-1 -: PW] + off_i[psel_i];
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
  import dds_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned NT = N_TW,
  parameter int unsigned NO = N_OFF,
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned FSW = (NT > 1) ? $clog2(NT) : 1,
  localparam int unsigned PSW = (NO > 1) ? $clog2(NO) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [FSW-1:0] fsel_i,
  input  logic [PSW-1:0] psel_i,
  output logic [FW-1:0]  acc_o,
  output logic [PW-1:0]  phase_o
);
  logic [NT-1:0][FW-1:0] tw_w;
  logic [NO-1:0][PW-1:0] off_w;
  logic [FW-1:0]         acc_nxt_w;

  dds_reg_bank #(
    .DW(DW), .FW(FW), .PW(PW), .NT(NT), .NO(NO), .AW(AW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tw_o      (tw_w),
    .off_o     (off_w)
  );

  dds_phase_acc #(.FW(FW), .NT(NT)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tw_i      (tw_w),
    .fsel_i    (fsel_i),
    .acc_o     (acc_o),
    .acc_nxt_o (acc_nxt_w)
  );

  dds_phase_offset #(.FW(FW), .PW(PW), .NO(NO)) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_nxt_i (acc_nxt_w),
    .off_i     (off_w),
    .psel_i    (psel_i),
    .phase_o   (phase_o)
  );
endmodule

// File: rtl/dds_phase_gen_chk.sv
module dds_phase_gen_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned FW = 32,
  parameter int unsigned PW = 12,
  parameter int unsigned NT = 2,
  parameter int unsigned NO = 4,
  parameter int unsigned AW = 3,
  localparam int unsigned FSW = (NT > 1) ? $clog2(NT) : 1,
  localparam int unsigned PSW = (NO > 1) ? $clog2(NO) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [AW-1:0]         wr_addr_i,
  input logic [DW-1:0]         wr_data_i,
  input logic [FSW-1:0]        fsel_i,
  input logic [PSW-1:0]        psel_i,
  input logic [FW-1:0]         acc_o,
  input logic [PW-1:0]         phase_o,
  input logic [NT-1:0][FW-1:0] tw_i,
  input logic [NO-1:0][PW-1:0] off_i
);
  // R2, R3: increment is the word chosen at the previous edge
  a_r2_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_o == FW'($past(acc_o) + $past(tw_i[fsel_i])));

  // R7: phase tracks accumulator top bits plus selected offset
  a_r7_phase_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == PW'(acc_o[FW-1 -: PW] + $past(off_i[psel_i])));

  // R10: no write, no register change
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(tw_i) && $stable(off_i));

  // R4: upper-half write to word 0 keeps its lower half
  a_r4_half_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == AW'(1) |=>
      tw_i[0][FW-1 -: DW] == $past(wr_data_i) && $stable(tw_i[0][DW-1:0]));

  // R5: last offset takes low data bits only
  a_r5_off_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == {AW{1'b1}} |=>
      off_i[NO-1] == $past(wr_data_i[PW-1:0]));
endmodule

bind dds_phase_gen dds_phase_gen_chk #(
  .DW(DW), .FW(FW), .PW(PW), .NT(NT), .NO(NO), .AW(AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .fsel_i    (fsel_i),
  .psel_i    (psel_i),
  .acc_o     (acc_o),
  .phase_o   (phase_o),
  .tw_i      (tw_w),
  .off_i     (off_w)
);

// File: tb/sim_dds_phase_gen.sv
module sim_dds_phase_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        fsel_i = 1'b0;
  logic [1:0]  psel_i = '0;
  logic [31:0] acc_o;
  logic [11:0] phase_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_tw [2];
  logic [11:0] m_off [4];
  logic [31:0] m_acc;

  always #2 clk_i = ~clk_i;

  dds_phase_gen u0 (.*);

  typedef struct packed {
    logic        en;
    logic [2:0]  addr;
    logic [15:0] data;
    logic        fsel;
    logic [1:0]  psel;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b1, 3'd0, 16'hE148, 1'b0, 2'd0},
    '{1'b1, 3'd1, 16'h547A, 1'b0, 2'd0},
    '{1'b1, 3'd2, 16'h0000, 1'b0, 2'd0},
    '{1'b1, 3'd3, 16'h1000, 1'b0, 2'd0},
    '{1'b1, 3'd4, 16'hF123, 1'b0, 2'd0},
    '{1'b1, 3'd5, 16'h0400, 1'b0, 2'd1},
    '{1'b1, 3'd6, 16'h3800, 1'b0, 2'd2},
    '{1'b1, 3'd7, 16'h0FFF, 1'b0, 2'd3},
    '{1'b0, 3'd0, 16'hFFFF, 1'b0, 2'd3},
    '{1'b0, 3'd4, 16'h0AAA, 1'b1, 2'd0},
    '{1'b0, 3'd7, 16'h5555, 1'b1, 2'd1},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 2'd2},
    '{1'b0, 3'd0, 16'h0000, 1'b0, 2'd3},
    '{1'b1, 3'd5, 16'hE00F, 1'b1, 2'd1},
    '{1'b0, 3'd0, 16'h0000, 1'b1, 2'd1},
    '{1'b0, 3'd0, 16'h0000, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    m_tw[0] = '0; m_tw[1] = '0;
    for (int i = 0; i < 4; i++) m_off[i] = '0;
    m_acc = '0;
  endtask

  task automatic step(input logic en, input logic [2:0] addr, input logic [15:0] data,
                      input logic fs, input logic [1:0] ps,
                      input string atag, input string ptag);
    logic [31:0] e_acc;
    logic [11:0] e_ph;
    @(negedge clk_i);
    wr_en_i = en; wr_addr_i = addr; wr_data_i = data; fsel_i = fs; psel_i = ps;
    e_acc = m_acc + m_tw[fs];
    e_ph  = e_acc[31:20] + m_off[ps];
    m_acc = e_acc;
    if (en) begin
      if (!addr[2]) begin
        if (addr[0]) m_tw[addr[1]][31:16] = data;
        else         m_tw[addr[1]][15:0]  = data;
      end else m_off[addr[1:0]] = data[11:0];
    end
    @(posedge clk_i);
    #1;
    chk(atag, acc_o, e_acc);
    chk(ptag, {20'd0, phase_o}, {20'd0, e_ph});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; fsel_i = 1'b0; psel_i = '0;
    model_clear();
    @(negedge clk_i);
    chk("R1", acc_o, 32'd0);
    chk("R1", {20'd0, phase_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    model_clear();
    repeat (2) @(negedge clk_i);
    do_reset();
    // R1: first clock after reset, no write, stays zero
    step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd0, "R1", "R1");

    foreach (VEC[i])
      step(VEC[i].en, VEC[i].addr, VEC[i].data, VEC[i].fsel, VEC[i].psel, "R2", "R7");

    // R4: write only upper half of word 0 (lower stays E148)
    step(1'b1, 3'd1, 16'h0002, 1'b0, 2'd0, "R4", "R7");
    a = acc_o;
    step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd0, "R4", "R7");
    chk("R4", acc_o - a, 32'h0002E148);

    // R8: write lower half; same edge uses old word, next edge new
    a = acc_o;
    step(1'b1, 3'd0, 16'h0000, 1'b0, 2'd0, "R8", "R7");
    chk("R8", acc_o - a, 32'h0002E148);
    a = acc_o;
    step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd0, "R8", "R7");
    chk("R8", acc_o - a, 32'h00020000);

    // R10: enable low, register unchanged
    step(1'b0, 3'd0, 16'hFFFF, 1'b0, 2'd0, "R10", "R7");
    a = acc_o;
    step(1'b0, 3'd1, 16'hFFFF, 1'b0, 2'd0, "R10", "R7");
    chk("R10", acc_o - a, 32'h00020000);

    // R3, R9: switch to word 1 without clearing accumulator
    a = acc_o;
    step(1'b0, 3'd0, 16'h0000, 1'b1, 2'd0, "R9", "R7");
    chk("R3", acc_o - a, m_tw[1]);
    chk("R9", acc_o, a + m_tw[1]);
    a = acc_o;
    step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd3, "R9", "R7");
    chk("R3", acc_o - a, 32'h00020000);

    // R5: high data bits dropped on offset write
    step(1'b1, 3'd6, 16'hA7FF, 1'b0, 2'd0, "R2", "R5");
    step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd2, "R2", "R5");
    chk("R5", {20'd0, 12'(phase_o - acc_o[31:20])}, 32'h7FF);

    // R6: each select picks its own offset
    for (int s = 0; s < 4; s++) begin
      step(1'b0, 3'd0, 16'h0000, 1'b0, 2'(s), "R2", "R6");
      chk("R6", {20'd0, 12'(phase_o - acc_o[31:20])}, {20'd0, m_off[s]});
    end

    // R2: wrap modulo 2^32
    do_reset();
    step(1'b1, 3'd0, 16'hFFFF, 1'b0, 2'd0, "R2", "R7");
    step(1'b1, 3'd1, 16'hFFFF, 1'b0, 2'd0, "R2", "R7");
    step(1'b1, 3'd7, 16'hFFFF, 1'b0, 2'd3, "R2", "R7");
    chk("R2", acc_o, 32'h0000FFFE);
    for (int i = 0; i < 6; i++) step(1'b0, 3'd0, 16'h0000, 1'b0, 2'd3, "R2", "R7");
    chk("R2", acc_o, 32'h0000FFF8);

    finish_run();
  end
endmodule